// File: doc/BRIEF.md
# Instruction Address Match Breakpoint

This unit gives a small processor core two hardware breakpoints. Software loads a 20-bit match address into each channel and turns the channel on with its own enable bit. At every instruction boundary the core presents the start address of the instruction it is about to execute. If an enabled channel holds that address, the unit raises a break request before the instruction runs. The core then stacks a program-counter value and vectors to its break handler.

The request cannot be masked. No global interrupt-enable flag or priority level reaches the unit, so nothing can block or delay a break. The value offered for stacking is not a true return address. It is the match address plus 2 when the core flags the instruction as belonging to the long opcode class, and the match address plus 1 otherwise. The handler has to fix up the stack before it returns.

The request is held until the core acknowledges it. While the request is held, the unit takes no notice of further boundaries. After an acknowledge, the same address cannot fire again until the core has presented a boundary at some other address. This keeps the core from looping on one breakpoint when it returns to the matched instruction.

Top module: `addr_break_unit`

## Requirements
- R1: After reset, both match registers read 0, both enables read 0 and `brk_req` is low.
- R2: A channel whose enable bit is 0 never raises a request, even when its match register equals the boundary address.
- R3: A boundary strobe whose address equals the match register of an enabled channel raises `brk_req` on the clock edge that samples the strobe, with no other gating.
- R4: `brk_pc` equals the boundary address plus 2 when `ibnd_long` is 1, and plus 1 when it is 0. The sum wraps modulo 2^20.
- R5: If both enabled channels match the same boundary, a single request is raised with `brk_chan` = 0. A match from channel 1 alone gives `brk_chan` = 1.
- R6: Once raised, `brk_req`, `brk_pc` and `brk_chan` hold steady until `brk_ack` is sampled high. `brk_req` is low from the next edge onward.
- R7: Boundary strobes that arrive while a request is pending are ignored and leave the outputs unchanged.
- R8: A configuration write is used from the next boundary onward. A boundary sampled on the same edge as the write is compared against the old values.
- R9: After a request is acknowledged, boundaries at the address that fired raise nothing until a boundary at a different address has been seen.
- R10: Configuration register map, selected by `cfg_addr`: 0 is the match address of channel 0, 1 is the match address of channel 1, and 2 holds the enables (bit 0 for channel 0, bit 1 for channel 1, other bits read 0). Address 3 reads 0 and ignores writes. `cfg_rdata` is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 20 | Configuration write data |
| cfg_rdata | output | 20 | Configuration read data |
| ibnd_valid | input | 1 | Instruction boundary strobe |
| ibnd_addr | input | 20 | Start address of the instruction about to execute |
| ibnd_long | input | 1 | 1 when that instruction is in the plus-2 opcode class |
| brk_req | output | 1 | Break request, held until acknowledged |
| brk_ack | input | 1 | Acknowledge pulse from the core |
| brk_chan | output | 1 | Channel that raised the request |
| brk_pc | output | 20 | Program-counter value to stack |

## Verification
A configuration write and an instruction boundary can land on the same clock edge. The bench provokes this by loading a new match address, and in a second case turning on an enable, in the very cycle that the boundary strobe carries that address. It expects no request on that boundary and a request on the next boundary at the same address. A second collision is a boundary strobe that arrives while a request is pending. The bench strobes a boundary that would match the other channel and checks that the held PC and channel do not change.

// File: rtl/addr_break_unit.sv
module addr_break_unit #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              ibnd_valid,
  input  logic [ADDR_W-1:0] ibnd_addr,
  input  logic              ibnd_long,
  output logic              brk_req,
  input  logic              brk_ack,
  output logic              brk_chan,
  output logic [ADDR_W-1:0] brk_pc
);
  localparam int NCH = 2;

  logic [NCH-1:0][ADDR_W-1:0] match_q;
  logic [NCH-1:0]             en_q;
  logic [NCH-1:0]             hit;
  logic                       sup_q;
  logic [ADDR_W-1:0]          sup_addr_q;
  logic                       suppressed;
  logic                       fire;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                  match_q[c] <= '0;
      else if (cfg_we && cfg_addr == 2'(c))        match_q[c] <= cfg_wdata;
    assign hit[c] = en_q[c] && (ibnd_addr == match_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          en_q <= '0;
    else if (cfg_we && cfg_addr == 2'd2) en_q <= cfg_wdata[NCH-1:0];

  always_comb
    case (cfg_addr)
      2'd0:    cfg_rdata = match_q[0];
      2'd1:    cfg_rdata = match_q[1];
      2'd2:    cfg_rdata = {{(ADDR_W-NCH){1'b0}}, en_q};
      default: cfg_rdata = '0;
    endcase

  assign suppressed = sup_q && (ibnd_addr == sup_addr_q);
  assign fire       = ibnd_valid && !brk_req && |hit && !suppressed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      brk_req    <= 1'b0;
      brk_chan   <= 1'b0;
      brk_pc     <= '0;
      sup_q      <= 1'b0;
      sup_addr_q <= '0;
    end else if (fire) begin
      brk_req    <= 1'b1;
      brk_chan   <= !hit[0];
      brk_pc     <= ibnd_addr + ADDR_W'(ibnd_long ? 2 : 1);
      sup_q      <= 1'b1;
      sup_addr_q <= ibnd_addr;
    end else begin
      if (brk_req && brk_ack) brk_req <= 1'b0;
      if (ibnd_valid && !brk_req && !suppressed) sup_q <= 1'b0;
    end
endmodule

module addr_break_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ibnd_valid,
  input logic [ADDR_W-1:0] ibnd_addr,
  input logic              ibnd_long,
  input logic              brk_req,
  input logic              brk_ack,
  input logic              brk_chan,
  input logic [ADDR_W-1:0] brk_pc,
  input logic [1:0]        en
);
  logic [1:0] en_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_d <= '0;
    else        en_d <= en;

  // R3
  req_after_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> $past(ibnd_valid));
  // R2
  enabled_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> en_d[brk_chan]);
  // R4
  pc_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> brk_pc == $past(ibnd_addr) + ADDR_W'($past(ibnd_long) ? 2 : 1));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !brk_ack) |=> brk_req && $stable(brk_pc) && $stable(brk_chan));
  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && brk_ack) |=> !brk_req);
endmodule

bind addr_break_unit addr_break_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk, .rst_n, .ibnd_valid, .ibnd_addr, .ibnd_long,
  .brk_req, .brk_ack, .brk_chan, .brk_pc, .en(en_q)
);

// File: tb/addr_break_unit_tb.sv
module addr_break_unit_tb;
  localparam int AW = 20;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [AW-1:0] cfg_wdata = 0;
  logic [AW-1:0] cfg_rdata;
  logic ibnd_valid = 0, ibnd_long = 0, brk_ack = 0;
  logic [AW-1:0] ibnd_addr = 0;
  logic brk_req, brk_chan; logic [AW-1:0] brk_pc;
  int checks = 0, errors = 0;
  logic [AW-1:0] m0 = 0, m1 = 0; logic [1:0] en = 0;
  logic sup = 0; logic [AW-1:0] supa = 0;

  always #2.5 clk = ~clk;

  addr_break_unit #(.ADDR_W(AW)) u_dut (.*);

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [AW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
    if (a == 0) m0 = d; else if (a == 1) m1 = d; else if (a == 2) en = d[1:0];
  endtask

  task automatic rd(string req, logic [1:0] a, logic [AW-1:0] exp);
    @(negedge clk); cfg_addr = a; #1 chk(req, cfg_rdata, exp);
  endtask

  task automatic bnd(string req, logic [AW-1:0] a, logic l);
    logic h0, h1, e;
    h0 = en[0] && a == m0; h1 = en[1] && a == m1;
    e = (h0 || h1) && !(sup && a == supa);
    if (!(sup && a == supa)) sup = 0;
    @(negedge clk); ibnd_valid = 1; ibnd_addr = a; ibnd_long = l;
    @(posedge clk); #1 ibnd_valid = 0;
    chk(req, AW'(brk_req), AW'(e));
    if (e) begin
      chk("R4", brk_pc, a + AW'(l ? 2 : 1));
      chk("R5", AW'(brk_chan), AW'(!h0));
      sup = 1; supa = a;
    end
  endtask

  task automatic ack();
    @(negedge clk); brk_ack = 1;
    @(posedge clk); #1 brk_ack = 0;
    chk("R6 drop", AW'(brk_req), 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] pc0; logic ch0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    chk("R1 req", AW'(brk_req), 0);
    for (int a = 0; a < 3; a++) rd("R1", 2'(a), 0);
    // R10
    wr(0, 20'hABCDE); wr(1, 20'h13579); wr(2, 20'hFFFFF); wr(3, 20'h55555);
    rd("R10 m0", 0, 20'hABCDE); rd("R10 m1", 1, 20'h13579);
    rd("R10 en", 2, 20'h3); rd("R10 a3", 3, 0);
    wr(2, 0);
    // R2/R3/R4/R5 sweep over enables, match patterns, opcode class
    for (int it = 0; it < 32; it++) begin
      logic [AW-1:0] a; int em, pat; logic l;
      a = AW'(20'hFFFE0 + it); em = it % 4; pat = (it / 4) % 4; l = it[3] ^ it[4] ^ it[0];
      case (pat)
        0: begin wr(0, a); wr(1, a ^ 4); end
        1: begin wr(0, a ^ 4); wr(1, a); end
        2: begin wr(0, a); wr(1, a); end
        default: begin wr(0, a ^ 1); wr(1, a ^ 2); end
      endcase
      wr(2, AW'(em));
      bnd(em == 0 ? "R2" : "R3", a, l);
      if (brk_req) ack();
    end
    // R4 wrap: FFFFF long -> 00001
    wr(0, 20'hFFFFF); wr(2, 1);
    bnd("R4 wrap", 20'hFFFFF, 1);
    chk("R4 wrap", brk_pc, 20'h00001);
    // R6/R7 hold while boundaries arrive
    wr(1, 20'h00400); wr(2, 3);
    pc0 = brk_pc; ch0 = brk_chan;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ibnd_valid = 1; ibnd_addr = 20'h00400; ibnd_long = 0;
      @(posedge clk); #1 ibnd_valid = 0;
      chk("R7 req", AW'(brk_req), 1);
      chk("R7 pc", brk_pc, pc0);
      chk("R6 chan", AW'(brk_chan), AW'(ch0));
    end
    ack();
    // R9 no retrigger on same address
    bnd("R9 same", 20'hFFFFF, 0);
    bnd("R9 same2", 20'hFFFFF, 1);
    bnd("R9 other", 20'h00010, 0);
    bnd("R9 rearm", 20'hFFFFF, 0);
    chk("R9 rearm", AW'(brk_req), 1);
    ack();
    // R8 write in the same cycle as a boundary uses old value
    wr(2, 1); wr(0, 20'h11111);
    bnd("R8 idle", 20'h22222, 0);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 0; cfg_wdata = 20'h33333;
    ibnd_valid = 1; ibnd_addr = 20'h33333; ibnd_long = 0;
    @(posedge clk); #1 cfg_we = 0; ibnd_valid = 0;
    m0 = 20'h33333;
    chk("R8 same edge", AW'(brk_req), 0);
    bnd("R8 next", 20'h33333, 1);
    if (brk_req) ack();
    // R8 enable written on the boundary edge
    wr(0, 20'h44444); wr(2, 0);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 2; cfg_wdata = 1;
    ibnd_valid = 1; ibnd_addr = 20'h44444;
    @(posedge clk); #1 cfg_we = 0; ibnd_valid = 0;
    en = 1;
    chk("R8 enable edge", AW'(brk_req), 0);
    bnd("R8 enable next", 20'h44444, 0);
    if (brk_req) ack();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule